// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block gathers a large set of level-sensitive interrupt lines, arranged in groups of eight, into one request line per group for a parent interrupt controller. Each source has its own enable bit. A group raises its request only while at least one of its sources is both pending and enabled. Alongside each request the block gives the position of the lowest-numbered enabled pending source in that group, so the handler can find the source to service first without scanning the status word.

Software reaches the block through a simple register port. Four groups share one 32-bit word, and group g sits in bits [8*(g%4)+7 : 8*(g%4)] of its bank. Each bank has one register to set enable bits, one to clear them, and one read-only view of the raw pending lines. Bank b, which serves groups 4b to 4b+3, starts at address b*0x10. The pending view follows the inputs. It keeps no sticky state, so a source stops showing as pending once its line drops.

Top module: `irq_comb_top`

## Requirements
- R1: After reset every enable bit is 0, every grp_irq and grp_idx_vld bit is 0, and reading offset 0x0 of a bank returns 0.
- R2: A write to bank offset 0x0 sets each enable bit whose data bit is 1 and leaves the enable bits whose data bit is 0 unchanged. The new value is visible after one clock.
- R3: A write to bank offset 0x4 clears each enable bit whose data bit is 1 and leaves the enable bits whose data bit is 0 unchanged. The new value is visible after one clock.
- R4: Reading bank offset 0xC returns the 32 input levels of that bank as sampled at the last clock edge, whether or not they are enabled. A bit returns to 0 one clock after its input drops.
- R5: Bank b sits at address b*0x10 and holds sources 32b to 32b+31. Source 32b+k appears in data bit k.
- R6: grp_irq[g] is 1 exactly when some source 8g+i (i = 0..7) has both its sampled level and its enable bit at 1. Masked pending sources raise no request.
- R7: grp_idx[3g+2:3g] holds the smallest i for which source 8g+i is enabled and pending, and grp_idx_vld[g] marks that such a source exists. When it does not, grp_idx_vld[g] is 0.
- R8: Reading bank offset 0x0 or 0x4 returns that bank's current enable mask.
- R9: Writes to any other offset (0x8, or any address with a nonzero low two bits), or to a bank at or beyond NUM_BANKS, change no enable bit. Reads from those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_BANKS*32 | Level interrupt sources |
| bus_wr | input | 1 | Write strobe for bus_addr/bus_wdata |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| grp_irq | output | NUM_BANKS*4 | One request line per group |
| grp_idx | output | NUM_BANKS*4*3 | Lowest enabled pending index, 3 bits per group |
| grp_idx_vld | output | NUM_BANKS*4 | Index valid per group |

## Verification
Input levels and enable writes each pass through one register. Request lines, index outputs and the status readback therefore respond one clock after the stimulus is applied. Read data is combinational from the stored state and the current address. The bench drives inputs on the falling edge and lets exactly one rising edge pass. It then sets the read address and samples all outputs a short delay later, still before the next rising edge. The same timing holds for every vector, so no result can be checked a cycle early or late.

// File: rtl/irq_comb_pkg.sv
package irq_comb_pkg;
    localparam int unsigned GRP_W        = 8;
    localparam int unsigned GRP_PER_BANK = 4;
    localparam int unsigned WORD_W       = GRP_W * GRP_PER_BANK;
    localparam int unsigned IDX_W        = $clog2(GRP_W);

    typedef enum logic [1:0] {
        REG_SET  = 2'd0,
        REG_CLR  = 2'd1,
        REG_STS  = 2'd2,
        REG_NONE = 2'd3
    } reg_kind_e;
endpackage

// File: rtl/irq_comb_dec.sv
module irq_comb_dec
    import irq_comb_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned ADDR_W    = 8
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_BANKS-1:0] bank_hit,
    output reg_kind_e            kind
);
    localparam int unsigned SEL_W = ADDR_W - 4;

    logic [SEL_W-1:0] sel;
    assign sel = addr[ADDR_W-1:4];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
        assign bank_hit[b] = (sel == SEL_W'(b));
    end

    always_comb begin
        unique case (addr[3:0])
            4'h0:    kind = REG_SET;
            4'h4:    kind = REG_CLR;
            4'hC:    kind = REG_STS;
            default: kind = REG_NONE;
        endcase
    end
endmodule

// File: rtl/irq_comb_lsb.sv
module irq_comb_lsb
    import irq_comb_pkg::*;
(
    input  logic [GRP_W-1:0] vec,
    output logic [IDX_W-1:0] idx,
    output logic             vld
);
    always_comb begin
        idx = '0;
        for (int i = GRP_W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
        vld = |vec;
    end
endmodule

// File: rtl/irq_comb_top.sv
module irq_comb_top
    import irq_comb_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned ADDR_W    = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NUM_BANKS*WORD_W-1:0]            irq_in,
    input  logic                                   bus_wr,
    input  logic [ADDR_W-1:0]                      bus_addr,
    input  logic [WORD_W-1:0]                      bus_wdata,
    output logic [WORD_W-1:0]                      bus_rdata,
    output logic [NUM_BANKS*GRP_PER_BANK-1:0]      grp_irq,
    output logic [NUM_BANKS*GRP_PER_BANK*IDX_W-1:0] grp_idx,
    output logic [NUM_BANKS*GRP_PER_BANK-1:0]      grp_idx_vld
);
    localparam int unsigned NUM_GROUPS = NUM_BANKS * GRP_PER_BANK;
    localparam int unsigned NUM_SRC    = NUM_BANKS * WORD_W;

    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic [NUM_SRC-1:0] sts;
    } state_t;

    state_t                st_d, st_q;
    logic [NUM_BANKS-1:0]  bank_hit;
    reg_kind_e             kind;

    irq_comb_dec #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W)
    ) u_dec (
        .addr     (bus_addr),
        .bank_hit (bank_hit),
        .kind     (kind)
    );

    always_comb begin
        st_d     = st_q;
        st_d.sts = irq_in;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_wr && bank_hit[b]) begin
                if (kind == REG_SET)
                    st_d.en[b*WORD_W +: WORD_W] = st_q.en[b*WORD_W +: WORD_W] | bus_wdata;
                else if (kind == REG_CLR)
                    st_d.en[b*WORD_W +: WORD_W] = st_q.en[b*WORD_W +: WORD_W] & ~bus_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_hit[b]) begin
                if (kind == REG_SET || kind == REG_CLR)
                    bus_rdata = st_q.en[b*WORD_W +: WORD_W];
                else if (kind == REG_STS)
                    bus_rdata = st_q.sts[b*WORD_W +: WORD_W];
            end
        end
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic [GRP_W-1:0] live;
        assign live = st_q.en[g*GRP_W +: GRP_W] & st_q.sts[g*GRP_W +: GRP_W];
        assign grp_irq[g] = |live;

        irq_comb_lsb u_lsb (
            .vec (live),
            .idx (grp_idx[g*IDX_W +: IDX_W]),
            .vld (grp_idx_vld[g])
        );
    end
endmodule

// File: rtl/irq_comb_chk.sv
module irq_comb_chk
    import irq_comb_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned ADDR_W    = 8
) (
    input logic                                    clk,
    input logic                                    rst_n,
    input logic [NUM_BANKS*WORD_W-1:0]             irq_in,
    input logic                                    bus_wr,
    input logic [ADDR_W-1:0]                       bus_addr,
    input logic [WORD_W-1:0]                       bus_wdata,
    input logic [NUM_BANKS*WORD_W-1:0]             en,
    input logic [NUM_BANKS*WORD_W-1:0]             sts,
    input logic [NUM_BANKS*GRP_PER_BANK-1:0]       grp_irq,
    input logic [NUM_BANKS*GRP_PER_BANK*IDX_W-1:0] grp_idx,
    input logic [NUM_BANKS*GRP_PER_BANK-1:0]       grp_idx_vld
);
    localparam int unsigned NUM_GROUPS = NUM_BANKS * GRP_PER_BANK;

    // R4: sampled levels follow the inputs by one clock
    p_sts_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> sts == $past(irq_in));

    // R2: set write to bank 0 leaves every written 1 enabled
    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == '0) |=>
            ((en[WORD_W-1:0] & $past(bus_wdata)) == $past(bus_wdata)));

    // R3: clear write to bank 0 leaves every written 1 disabled
    p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(4)) |=>
            ((en[WORD_W-1:0] & $past(bus_wdata)) == '0));

    // R9: idle cycles and unmapped writes keep the enables
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr || bus_addr[1:0] != 2'b00 || bus_addr[3:0] == 4'h8) |=> $stable(en));

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
        logic [GRP_W-1:0] live;
        logic [IDX_W-1:0] pick;
        logic [GRP_W-1:0] below;
        assign live  = en[g*GRP_W +: GRP_W] & sts[g*GRP_W +: GRP_W];
        assign pick  = grp_idx[g*IDX_W +: IDX_W];
        assign below = (GRP_W'(1) << pick) - GRP_W'(1);

        // R6: request line agrees with the encoder's valid flag
        p_req_vld_r6: assert property (@(posedge clk) disable iff (!rst_n)
            grp_irq[g] == grp_idx_vld[g]);

        // R7: chosen index is live and nothing lower is live
        p_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
            grp_idx_vld[g] |-> (live[pick] && ((live & below) == '0)));
    end
endmodule

bind irq_comb_top irq_comb_chk #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_in      (irq_in),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .en          (st_q.en),
    .sts         (st_q.sts),
    .grp_irq     (grp_irq),
    .grp_idx     (grp_idx),
    .grp_idx_vld (grp_idx_vld)
);

// File: tb/sim_irq_comb_top.sv
module sim_irq_comb_top;
    localparam int CLK_PERIOD = 10;
    localparam int VW = 64 + 1 + 8 + 32 + 8 + 32 + 8;
    localparam int NV = 8;

    // {irq, wr, waddr, wdata, raddr, exp_rdata, exp_req}
    localparam logic [VW-1:0] VEC [NV] = '{
        {64'h0, 1'b1, 8'h00, 32'h0000_00FF, 8'h00, 32'h0000_00FF, 8'h00},
        {64'h5, 1'b0, 8'h00, 32'h0,         8'h0C, 32'h0000_0005, 8'h01},
        {64'h500, 1'b0, 8'h00, 32'h0,       8'h0C, 32'h0000_0500, 8'h00},
        {64'h30, 1'b1, 8'h04, 32'h0000_000F, 8'h04, 32'h0000_00F0, 8'h01},
        {64'h8000_0000_0000_0000, 1'b1, 8'h10, 32'hFF00_0000, 8'h1C, 32'h8000_0000, 8'h80},
        {64'h0, 1'b1, 8'h08, 32'hFFFF_FFFF, 8'h08, 32'h0,         8'h00},
        {64'h0, 1'b0, 8'h00, 32'h0,         8'h00, 32'h0000_00F0, 8'h00},
        {64'h0, 1'b1, 8'h20, 32'hFFFF_FFFF, 8'h10, 32'hFF00_0000, 8'h00}
    };
    localparam string VTAG [NV] = '{"R2", "R4", "R6", "R3", "R5", "R9", "R8", "R9"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_in = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  grp_irq;
    logic [23:0] grp_idx;
    logic [7:0]  grp_idx_vld;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_comb_top #(.NUM_BANKS(2), .ADDR_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .grp_irq(grp_irq), .grp_idx(grp_idx), .grp_idx_vld(grp_idx_vld)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // drive, let one rising edge pass, then point the read address
    task automatic step(input logic [63:0] irq, input logic wr, input logic [7:0] wa,
                        input logic [31:0] wd, input logic [7:0] ra);
        @(negedge clk);
        irq_in = irq; bus_wr = wr; bus_addr = wa; bus_wdata = wd;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = ra;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        irq_in = 64'hFFFF_FFFF_FFFF_FFFF;
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state with all inputs high
        check("R1 req", {56'h0, grp_irq}, 64'h0);
        check("R1 vld", {56'h0, grp_idx_vld}, 64'h0);
        check("R1 en read", {32'h0, bus_rdata}, 64'h0);
        @(negedge clk); rst_n = 1'b1; irq_in = '0;

        for (int v = 0; v < NV; v++) begin
            logic [VW-1:0] e;
            e = VEC[v];
            step(e[152:89], e[88], e[87:80], e[79:48], e[47:40]);
            check({VTAG[v], " rdata"}, {32'h0, bus_rdata}, {32'h0, e[39:8]});
            check({VTAG[v], " req"}, {56'h0, grp_irq}, {56'h0, e[7:0]});
        end

        // R7: group 7 index from bit 63
        step(64'h8000_0000_0000_0000, 1'b0, 8'h00, 32'h0, 8'h1C);
        check("R7 idx g7", {61'h0, grp_idx[23:21]}, 64'd7);
        check("R7 vld g7", {63'h0, grp_idx_vld[7]}, 64'd1);

        // R7: lowest pending wins in group 2
        step(64'h0, 1'b1, 8'h00, 32'h00FF_0000, 8'h00);
        check("R2 en g2", {32'h0, bus_rdata}, 64'h00FF_00F0);
        step(64'h00A4_0000, 1'b0, 8'h00, 32'h0, 8'h0C);
        check("R7 idx lowest", {61'h0, grp_idx[8:6]}, 64'd2);
        check("R7 vld", {63'h0, grp_idx_vld[2]}, 64'd1);
        step(64'h00A0_0000, 1'b0, 8'h00, 32'h0, 8'h0C);
        check("R7 idx next", {61'h0, grp_idx[8:6]}, 64'd5);

        // R4: status clears when input drops
        step(64'h0, 1'b0, 8'h00, 32'h0, 8'h0C);
        check("R4 clear", {32'h0, bus_rdata}, 64'h0);
        check("R6 no req", {56'h0, grp_irq}, 64'h0);
        check("R7 no vld", {56'h0, grp_idx_vld}, 64'h0);

        // R2: zeros written to set change nothing
        step(64'h0, 1'b1, 8'h00, 32'h0, 8'h04);
        check("R2 zero set", {32'h0, bus_rdata}, 64'h00FF_00F0);
        // R3: zeros written to clear change nothing
        step(64'h0, 1'b1, 8'h04, 32'h0, 8'h00);
        check("R3 zero clr", {32'h0, bus_rdata}, 64'h00FF_00F0);

        // R9: unaligned write ignored, unaligned read is 0
        step(64'h0, 1'b1, 8'h01, 32'hFFFF_FFFF, 8'h01);
        check("R9 unaligned read", {32'h0, bus_rdata}, 64'h0);
        bus_addr = 8'h00; #1;
        check("R9 unaligned write", {32'h0, bus_rdata}, 64'h00FF_00F0);

        // R6: masked source shows in status but raises nothing
        step(64'h0000_0001_0000_0000, 1'b0, 8'h00, 32'h0, 8'h1C);
        check("R6 masked sts", {32'h0, bus_rdata}, 64'h1);
        check("R6 masked req", {56'h0, grp_irq}, 64'h0);

        // R1: reset again clears enables
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; bus_addr = 8'h10; #1;
        check("R1 reset en", {32'h0, bus_rdata}, 64'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule